// File: doc/BRIEF.md
# Root port error status collector

This block sits at the top of a PCI Express root port and collects the error messages that reach it. Each message has a severity class (correctable, non-fatal or fatal) and a 16-bit requester source identifier. The block keeps the root error status flags and two source capture registers, one for correctable and one for uncorrectable messages. In each class only the first message of a burst is recorded in detail, and later ones only raise a "more than one" flag.

Software enables reporting per class in a three-bit root command register and clears status flags by writing ones. The advanced error interrupt works in one of two modes. In level mode it is a line that stays high while any enabled class has a pending flag. In message mode it is a one-cycle pulse, sent together with an interrupt vector number, and only when the enabled condition goes from false to true. The vector number cannot be written by software through the status path. It is loaded through a separate side input.

Top module: `rpe_root_collector`

## Requirements
- R1: After reset the root command register, every status flag, both source capture registers and the vector number are zero, and `irq_level` and `irq_pulse` are low.
- R2: A message is sampled on the clock edge where `msg_valid` is high. `msg_sev` = 0 means correctable. If status bit 0 (correctable received) is clear, a correctable message captures `msg_src` into `cor_src`. If bit 0 is already set, the message sets bit 1 (multiple correctable) and leaves `cor_src` unchanged. In both cases bit 0 is set afterwards.
- R3: `msg_sev` = 1 (non-fatal) and `msg_sev` = 2 (fatal) are uncorrectable. If status bit 2 (uncorrectable received) is clear, an uncorrectable message captures `msg_src` into `uncor_src`. If bit 2 is already set, the message sets bit 3 (multiple uncorrectable) and keeps `uncor_src`. Bit 2 is then set. A non-fatal message also sets bit 5.
- R4: A fatal message sets bit 6. It sets bit 4 (first uncorrectable was fatal) only when bit 2 was clear before that message.
- R5: A message with `msg_sev` = 3 changes no status flag, no capture register and raises no interrupt.
- R6: When `sts_clr_en` is high, each status bit whose `sts_clr_mask` bit is 1 is cleared, and mask bits of 0 leave their flags unchanged. If a message arrives in the same cycle, it is applied to the status after the clear.
- R7: `cmd_wr_en` loads `cmd_wr_data` into `root_cmd`. Bit 0 enables correctable, bit 1 non-fatal and bit 2 fatal reporting, and they pair with status bits 0, 5 and 6. A command write in the same cycle as a message takes effect first.
- R8: In message mode (`msg_mode` = 1), a message whose class is enabled pulses `irq_pulse` high for the one cycle after its edge. It does so only if no enabled class was already pending beforehand.
- R9: In message mode, a command write pulses `irq_pulse` once when it changes the enabled condition (command AND pending classes) from none to some. A write that leaves it true, or makes it true from true, does not pulse.
- R10: In level mode (`msg_mode` = 0), `irq_level` equals the OR of the enabled pending classes and `irq_pulse` stays low. In message mode `irq_level` stays low.
- R11: `vec_load_en` loads `vec_load_data` into the vector number shown on `irq_vec`. Status clears do not change the vector number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An error message is presented this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 ignored |
| msg_src | input | SRC_W | Requester source identifier of the message |
| cmd_wr_en | input | 1 | Write strobe for the root command register |
| cmd_wr_data | input | 3 | New enables: bit 0 correctable, bit 1 non-fatal, bit 2 fatal |
| sts_clr_en | input | 1 | Write-one-to-clear strobe for the status flags |
| sts_clr_mask | input | 7 | Flags to clear |
| vec_load_en | input | 1 | Side load strobe for the interrupt vector number |
| vec_load_data | input | VEC_W | Vector number to load |
| msg_mode | input | 1 | 1: message-pulse interrupt, 0: level interrupt |
| root_cmd | output | 3 | Root command register |
| root_sts | output | 7 | Status flags (bits 0..6 as in the requirements) |
| cor_src | output | SRC_W | Captured correctable source identifier |
| uncor_src | output | SRC_W | Captured uncorrectable source identifier |
| irq_vec | output | VEC_W | Interrupt vector number |
| irq_level | output | 1 | Level interrupt line |
| irq_pulse | output | 1 | One-cycle interrupt message strobe |

## Verification
A wrong first-or-repeat decision shows up one cycle after the second message of a class. Either a capture register is overwritten or a multiple flag stays low, so the bench always sends pairs of messages in the same class. A wrong view of what was pending shows up as a missing or extra pulse in the cycle right after the message or command write. The bench therefore sends messages with other classes already pending, and command writes that do and do not cross from false to true. A clear-ordering mistake is only visible when a clear and a message fall in the same cycle, so that case is exercised directly.

// File: rtl/rpe_pkg.sv
package rpe_pkg;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_RSVD     = 2'd3
  } sev_e;

  localparam int STS_W   = 7;
  localparam int CLS_W   = 3;
  localparam int B_COR   = 0;
  localparam int B_MCOR  = 1;
  localparam int B_UNC   = 2;
  localparam int B_MUNC  = 3;
  localparam int B_FIRST = 4;
  localparam int B_NF    = 5;
  localparam int B_FAT   = 6;

  // one-hot enable bit that a severity maps to
  function automatic logic [CLS_W-1:0] sev_enable(input sev_e s);
    case (s)
      SEV_COR:      return 3'b001;
      SEV_NONFATAL: return 3'b010;
      SEV_FATAL:    return 3'b100;
      default:      return 3'b000;
    endcase
  endfunction

  // pending classes in the command bit order
  function automatic logic [CLS_W-1:0] classes_seen(input logic [STS_W-1:0] s);
    return {s[B_FAT], s[B_NF], s[B_COR]};
  endfunction

  // status after folding one message into it
  function automatic logic [STS_W-1:0] fold_message(input logic [STS_W-1:0] s,
                                                    input sev_e sev);
    logic [STS_W-1:0] n;
    n = s;
    case (sev)
      SEV_COR: begin
        if (s[B_COR]) n[B_MCOR] = 1'b1;
        n[B_COR] = 1'b1;
      end
      SEV_NONFATAL, SEV_FATAL: begin
        if (sev == SEV_FATAL) begin
          if (!s[B_UNC]) n[B_FIRST] = 1'b1;
          n[B_FAT] = 1'b1;
        end else begin
          n[B_NF] = 1'b1;
        end
        if (s[B_UNC]) n[B_MUNC] = 1'b1;
        n[B_UNC] = 1'b1;
      end
      default: n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rpe_cmd_reg.sv
module rpe_cmd_reg
  import rpe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CLS_W-1:0] wr_data,
  output logic [CLS_W-1:0] cmd_q,
  output logic [CLS_W-1:0] cmd_eff
);

  assign cmd_eff = wr_en ? wr_data : cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_eff;
  end

  // R7: the command register only moves on a write strobe
  a_r7_cmd_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_q) |-> $past(wr_en));

endmodule

// File: rtl/rpe_status_reg.sv
module rpe_status_reg
  import rpe_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             clr_en,
  input  logic [STS_W-1:0] clr_mask,
  output logic [STS_W-1:0] sts_q,
  output logic [STS_W-1:0] sts_base,
  output logic [SRC_W-1:0] cor_src,
  output logic [SRC_W-1:0] uncor_src
);

  sev_e             sev;
  logic             take_cor;
  logic             take_unc;
  logic             first_cor;
  logic             first_unc;
  logic [STS_W-1:0] sts_next;

  assign sev       = sev_e'(msg_sev);
  assign sts_base  = clr_en ? (sts_q & ~clr_mask) : sts_q;
  assign take_cor  = msg_valid && (sev == SEV_COR);
  assign take_unc  = msg_valid && ((sev == SEV_NONFATAL) || (sev == SEV_FATAL));
  assign first_cor = take_cor && !sts_base[B_COR];
  assign first_unc = take_unc && !sts_base[B_UNC];
  assign sts_next  = msg_valid ? fold_message(sts_base, sev) : sts_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q     <= '0;
      cor_src   <= '0;
      uncor_src <= '0;
    end else begin
      sts_q <= sts_next;
      if (first_cor) cor_src   <= msg_src;
      if (first_unc) uncor_src <= msg_src;
    end
  end

  // R2: correctable capture only changes on a correctable message
  a_r2_cor_src_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cor_src) |-> $past(msg_valid && msg_sev == 2'd0));

  // R2: multiple-correctable rises only over an already pending correctable
  a_r2_multi_cor_prior: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[B_MCOR]) |-> $past(sts_q[B_COR]));

  // R3: uncorrectable capture only changes on an uncorrectable message
  a_r3_unc_src_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(uncor_src) |-> $past(msg_valid && (msg_sev == 2'd1 || msg_sev == 2'd2)));

  // R4: first-fatal flag only rises on a fatal message
  a_r4_first_fatal_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[B_FIRST]) |-> $past(msg_valid && msg_sev == 2'd2));

  // R5: the reserved severity leaves the status untouched
  a_r5_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd3 && !clr_en) |=> $stable(sts_q));

endmodule

// File: rtl/rpe_irq_gen.sv
module rpe_irq_gen
  import rpe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_mode,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic             cmd_wr_en,
  input  logic [CLS_W-1:0] cmd_q,
  input  logic [CLS_W-1:0] cmd_eff,
  input  logic [STS_W-1:0] sts_q,
  input  logic [STS_W-1:0] sts_base,
  output logic             irq_level,
  output logic             irq_pulse
);

  logic msg_fire;
  logic wr_fire;
  logic was_on;
  logic now_on;

  // message path: class enabled and nothing enabled pending beforehand
  assign msg_fire = msg_mode && msg_valid &&
                    (|(sev_enable(sev_e'(msg_sev)) & cmd_eff)) &&
                    !(|(cmd_eff & classes_seen(sts_base)));

  // command path: enabled condition crosses from false to true
  assign was_on  = |(cmd_q & classes_seen(sts_q));
  assign now_on  = |(cmd_eff & classes_seen(sts_q));
  assign wr_fire = msg_mode && cmd_wr_en && !was_on && now_on;

  assign irq_level = !msg_mode && (|(cmd_q & classes_seen(sts_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= msg_fire || wr_fire;
  end

  // R8: a pulse always follows a message or a command write
  a_r8_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(msg_valid || cmd_wr_en));

  // R10: no pulse comes out of level mode
  a_r10_pulse_only_msg_mode: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(msg_mode));

  // R9: a write-caused pulse needs a pending class behind a new enable
  a_r9_write_pulse_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && !$past(msg_valid)) |-> $past(|classes_seen(sts_q)));

endmodule

// File: rtl/rpe_root_collector.sv
module rpe_root_collector
  import rpe_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             cmd_wr_en,
  input  logic [2:0]       cmd_wr_data,
  input  logic             sts_clr_en,
  input  logic [6:0]       sts_clr_mask,
  input  logic             vec_load_en,
  input  logic [VEC_W-1:0] vec_load_data,
  input  logic             msg_mode,
  output logic [2:0]       root_cmd,
  output logic [6:0]       root_sts,
  output logic [SRC_W-1:0] cor_src,
  output logic [SRC_W-1:0] uncor_src,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_level,
  output logic             irq_pulse
);

  logic [CLS_W-1:0] cmd_eff;
  logic [STS_W-1:0] sts_base;
  logic [VEC_W-1:0] vec_q;

  rpe_cmd_reg u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd_wr_en),
    .wr_data (cmd_wr_data),
    .cmd_q   (root_cmd),
    .cmd_eff (cmd_eff)
  );

  rpe_status_reg #(.SRC_W(SRC_W)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_sev   (msg_sev),
    .msg_src   (msg_src),
    .clr_en    (sts_clr_en),
    .clr_mask  (sts_clr_mask),
    .sts_q     (root_sts),
    .sts_base  (sts_base),
    .cor_src   (cor_src),
    .uncor_src (uncor_src)
  );

  rpe_irq_gen u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_mode  (msg_mode),
    .msg_valid (msg_valid),
    .msg_sev   (msg_sev),
    .cmd_wr_en (cmd_wr_en),
    .cmd_q     (root_cmd),
    .cmd_eff   (cmd_eff),
    .sts_q     (root_sts),
    .sts_base  (sts_base),
    .irq_level (irq_level),
    .irq_pulse (irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           vec_q <= '0;
    else if (vec_load_en) vec_q <= vec_load_data;
  end

  assign irq_vec = vec_q;

  // R11: vector number only changes through the side load
  a_r11_vec_side_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vec_q) |-> $past(vec_load_en));

  // R10: the level line is silent in message mode
  a_r10_level_quiet_msg: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |-> !irq_level);

endmodule

// File: tb/rpe_root_collector_tb.sv
module rpe_root_collector_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        msg_valid;
  logic [1:0]  msg_sev;
  logic [15:0] msg_src;
  logic        cmd_wr_en;
  logic [2:0]  cmd_wr_data;
  logic        sts_clr_en;
  logic [6:0]  sts_clr_mask;
  logic        vec_load_en;
  logic [4:0]  vec_load_data;
  logic        msg_mode;
  logic [2:0]  root_cmd;
  logic [6:0]  root_sts;
  logic [15:0] cor_src;
  logic [15:0] uncor_src;
  logic [4:0]  irq_vec;
  logic        irq_level;
  logic        irq_pulse;

  always #4 clk = ~clk;

  rpe_root_collector u_dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_src(msg_src), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .sts_clr_en(sts_clr_en), .sts_clr_mask(sts_clr_mask),
    .vec_load_en(vec_load_en), .vec_load_data(vec_load_data),
    .msg_mode(msg_mode), .root_cmd(root_cmd), .root_sts(root_sts),
    .cor_src(cor_src), .uncor_src(uncor_src), .irq_vec(irq_vec),
    .irq_level(irq_level), .irq_pulse(irq_pulse)
  );

  typedef struct {
    string       tag;
    logic [6:0]  sts;
    logic [2:0]  cmd;
    logic [15:0] csrc;
    logic [15:0] usrc;
    logic [4:0]  vec;
    logic        lvl;
    logic        pls;
  } exp_t;

  exp_t sb[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // bench-side model state
  logic [6:0]  m_sts  = '0;
  logic [2:0]  m_cmd  = '0;
  logic [15:0] m_csrc = '0;
  logic [15:0] m_usrc = '0;
  logic [4:0]  m_vec  = '0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(input string tag,
                      input logic mv, input logic [1:0] ms, input logic [15:0] src,
                      input logic cw, input logic [2:0] cd,
                      input logic cl, input logic [6:0] cm,
                      input logic vl, input logic [4:0] vd,
                      input logic mode);
    logic [6:0] base, nxt;
    logic [2:0] cmd_n, pend_old, pend_base, sevbit;
    logic       fire;
    exp_t       e;
    @(negedge clk);
    msg_valid = mv; msg_sev = ms; msg_src = src;
    cmd_wr_en = cw; cmd_wr_data = cd;
    sts_clr_en = cl; sts_clr_mask = cm;
    vec_load_en = vl; vec_load_data = vd;
    msg_mode = mode;

    base      = cl ? (m_sts & ~cm) : m_sts;
    cmd_n     = cw ? cd : m_cmd;
    pend_old  = {m_sts[6], m_sts[5], m_sts[0]};
    pend_base = {base[6], base[5], base[0]};
    nxt       = base;
    fire      = 1'b0;
    if (mv && ms != 2'd3) begin
      if (ms == 2'd0) begin
        sevbit = 3'b001;
        if (base[0]) nxt[1] = 1'b1; else m_csrc = src;
        nxt[0] = 1'b1;
      end else begin
        sevbit = (ms == 2'd1) ? 3'b010 : 3'b100;
        if (ms == 2'd2) begin
          if (!base[2]) nxt[4] = 1'b1;
          nxt[6] = 1'b1;
        end else begin
          nxt[5] = 1'b1;
        end
        if (base[2]) nxt[3] = 1'b1; else m_usrc = src;
        nxt[2] = 1'b1;
      end
      if (mode && (cmd_n & sevbit) != 0 && (cmd_n & pend_base) == 0) fire = 1'b1;
    end
    if (mode && cw && (m_cmd & pend_old) == 0 && (cd & pend_old) != 0) fire = 1'b1;
    m_sts = nxt;
    m_cmd = cmd_n;
    if (vl) m_vec = vd;

    e.tag  = tag;
    e.sts  = m_sts;
    e.cmd  = m_cmd;
    e.csrc = m_csrc;
    e.usrc = m_usrc;
    e.vec  = m_vec;
    e.lvl  = !mode && ((m_cmd & {m_sts[6], m_sts[5], m_sts[0]}) != 0);
    e.pls  = fire;
    sb.push_back(e);
  endtask

  // monitor: compares after each edge, well before the next drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "root_sts",  32'(root_sts),  32'(e.sts));
        chk(e.tag, "root_cmd",  32'(root_cmd),  32'(e.cmd));
        chk(e.tag, "cor_src",   32'(cor_src),   32'(e.csrc));
        chk(e.tag, "uncor_src", 32'(uncor_src), 32'(e.usrc));
        chk(e.tag, "irq_vec",   32'(irq_vec),   32'(e.vec));
        chk(e.tag, "irq_level", 32'(irq_level), 32'(e.lvl));
        chk(e.tag, "irq_pulse", 32'(irq_pulse), 32'(e.pls));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    msg_valid = 0; msg_sev = 0; msg_src = 0; cmd_wr_en = 0; cmd_wr_data = 0;
    sts_clr_en = 0; sts_clr_mask = 0; vec_load_en = 0; vec_load_data = 0;
    msg_mode = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    step("R1", 0, 2'd0, 16'h0, 0, 3'b000, 0, 7'h00, 0, 5'd0, 1);
    // message mode
    step("R11", 0, 2'd0, 16'h0, 0, 3'b000, 0, 7'h00, 1, 5'd9, 1);
    step("R2", 1, 2'd0, 16'h1111, 0, 3'b000, 0, 7'h00, 0, 5'd0, 1);
    step("R2", 1, 2'd0, 16'h2222, 0, 3'b000, 0, 7'h00, 0, 5'd0, 1);
    step("R5", 1, 2'd3, 16'hdead, 0, 3'b000, 0, 7'h00, 0, 5'd0, 1);
    step("R9", 0, 2'd0, 16'h0, 1, 3'b001, 0, 7'h00, 0, 5'd0, 1);
    step("R9", 0, 2'd0, 16'h0, 1, 3'b011, 0, 7'h00, 0, 5'd0, 1);
    step("R6", 0, 2'd0, 16'h0, 0, 3'b000, 1, 7'h7f, 0, 5'd0, 1);
    step("R8", 1, 2'd1, 16'h3333, 0, 3'b000, 0, 7'h00, 0, 5'd0, 1);
    step("R4", 1, 2'd2, 16'h4444, 0, 3'b000, 0, 7'h00, 0, 5'd0, 1);
    step("R6", 0, 2'd0, 16'h0, 0, 3'b000, 1, 7'h6c, 0, 5'd0, 1);
    step("R7", 0, 2'd0, 16'h0, 1, 3'b111, 0, 7'h00, 0, 5'd0, 1);
    step("R4", 1, 2'd2, 16'h5555, 0, 3'b000, 0, 7'h00, 0, 5'd0, 1);
    step("R8", 1, 2'd0, 16'h6666, 0, 3'b000, 0, 7'h00, 0, 5'd0, 1);
    step("R6", 0, 2'd0, 16'h0, 0, 3'b000, 1, 7'h00, 0, 5'd0, 1);
    step("R6", 1, 2'd0, 16'h7777, 0, 3'b000, 1, 7'h01, 0, 5'd0, 1);
    step("R3", 1, 2'd1, 16'h9999, 0, 3'b000, 0, 7'h00, 0, 5'd0, 1);
    // level mode
    step("R10", 0, 2'd0, 16'h0, 0, 3'b000, 0, 7'h00, 0, 5'd0, 0);
    step("R10", 0, 2'd0, 16'h0, 0, 3'b000, 1, 7'h7f, 0, 5'd0, 0);
    step("R10", 0, 2'd0, 16'h0, 1, 3'b001, 0, 7'h00, 0, 5'd0, 0);
    step("R10", 1, 2'd0, 16'h8888, 0, 3'b000, 0, 7'h00, 0, 5'd0, 0);
    step("R11", 0, 2'd0, 16'h0, 0, 3'b000, 0, 7'h00, 1, 5'd3, 0);
    step("R11", 0, 2'd0, 16'h0, 0, 3'b000, 1, 7'h7f, 0, 5'd0, 0);
    step("R10", 1, 2'd0, 16'hAAAA, 0, 3'b000, 0, 7'h00, 0, 5'd0, 0);
    step("R7", 0, 2'd0, 16'h0, 1, 3'b000, 0, 7'h00, 0, 5'd0, 0);
    step("R7", 0, 2'd0, 16'h0, 0, 3'b000, 0, 7'h00, 0, 5'd0, 0);

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule